// File: doc/BRIEF.md
# Pull-Handshake Codeword Stream Adapter

This block sits between a producer that hands out symbols only when asked, through a read-enable with one cycle of latency, and a consumer that expects an ordinary valid/ready stream. Each symbol is `SYM_W` bits wide and carries three tags: a first-of-codeword marker, a last-of-codeword marker and an erasure mark. The adapter raises its enable towards the producer whenever its small internal buffer can absorb the symbol that would come back one cycle later. It accepts a symbol only when the producer's valid is high in the cycle after an enable it granted. Accepted symbols leave in order, unchanged, on the valid/ready side.

While symbols pass through, a position counter checks every codeword against the fixed length `CW_LEN`. A codeword that does not open with its first-marker, a first-marker that appears inside a codeword, or a last-marker that is missing or misplaced sets a sticky error flag. The symbols themselves are still forwarded. No arithmetic is done on the symbol values.

Top module: `cw_pull_adapter`

## Requirements
- R1: While `rst` is high, `rd_en` is 0. In the first cycle after reset is released, `out_valid` and `frame_err` are 0 and the buffer is empty.
- R2: A symbol is accepted only in a cycle where `in_val` is 1 and `rd_en` was 1 in the previous cycle. While `rd_en` is low the producer holds `in_val` and its data, and that held value is never taken a second time.
- R3: Accepted symbols appear on the output in arrival order. `out_sym`, `out_sop`, `out_eop` and `out_erase` equal the input values of the same symbol.
- R4: Once `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` 1 with the same symbol and tags.
- R5: When `out_ready` stays low, `rd_en` goes low as soon as the `DEPTH` buffer slots would otherwise be overrun by symbols still in flight. No symbol is lost, however long the stall lasts.
- R6: With `out_ready` held at 1 and a producer that always has data, one symbol leaves per cycle, so a run of K symbols spans K consecutive output cycles.
- R7: If a symbol is accepted where a codeword must start (after reset or after a codeword end) and `in_sop` is 0, `frame_err` is set.
- R8: If `in_sop` is 1 on a symbol that is not at a codeword start, `frame_err` is set.
- R9: If `in_eop` is 1 at any position other than `CW_LEN`, or is 0 on the symbol at position `CW_LEN`, `frame_err` is set. Position numbering starts at 1 on the first-marker symbol.
- R10: `frame_err` stays 0 on a stream of well-formed codewords of length `CW_LEN`. Once set, it stays 1 until reset, even if well-formed codewords follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | output | 1 | Read-enable to the producer; the data it requests arrives one cycle later |
| in_val | input | 1 | Producer data valid, meaningful when `rd_en` was high the cycle before |
| in_sop | input | 1 | First symbol of a codeword |
| in_eop | input | 1 | Last symbol of a codeword |
| in_sym | input | SYM_W | Input symbol |
| in_erase | input | 1 | Erasure mark of the input symbol |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Consumer accepts the output symbol |
| out_sop | output | 1 | First-of-codeword tag of the output symbol |
| out_eop | output | 1 | Last-of-codeword tag of the output symbol |
| out_sym | output | SYM_W | Output symbol |
| out_erase | output | 1 | Erasure mark of the output symbol |
| frame_err | output | 1 | Sticky codeword framing error |

## Verification
Two things can happen in the same cycle. The consumer can drop `out_ready` while a symbol requested in the previous cycle is still arriving, so the buffer has to take the late arrival and also stop `rd_en`. The bench provokes this with a long ready stall that starts in the middle of a full-rate stream, and with alternating and pseudo-random ready patterns, some combined with producer gaps. It judges the result by checking that `rd_en` is low during the stall and that every symbol comes out exactly once, in order, with its tags intact. Framing faults are placed in the middle of streams that keep flowing, so the bench also checks that the error flag sets while the data still passes through unchanged.

// File: rtl/cwpa_pkg.sv
package cwpa_pkg;

    // Tags that travel alongside every symbol.
    typedef struct packed {
        logic sop;
        logic eop;
        logic erase;
    } sym_tag_t;

    localparam int TAG_W = $bits(sym_tag_t);

    typedef enum logic [1:0] {
        FE_NONE    = 2'd0,
        FE_NO_SOP  = 2'd1,
        FE_MID_SOP = 2'd2,
        FE_BAD_EOP = 2'd3
    } frame_fault_e;

    // Decide whether one accepted symbol breaks codeword framing.
    function automatic frame_fault_e judge_symbol(
        input logic sop,
        input logic eop,
        input logic at_start,
        input logic at_last
    );
        if (at_start && !sop)       return FE_NO_SOP;
        else if (!at_start && sop)  return FE_MID_SOP;
        else if (eop != at_last)    return FE_BAD_EOP;
        else                        return FE_NONE;
    endfunction

endpackage

// File: rtl/cwpa_pull_ctrl.sv
module cwpa_pull_ctrl #(
    parameter int DEPTH = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fill,
    input  logic             pop,
    input  logic             in_val,
    output logic             rd_en,
    output logic             push
);
    localparam int EW = CNT_W + 1;

    logic          req_q;
    logic [EW-1:0] committed;
    logic [EW-1:0] capacity;

    // Slots already owned: stored symbols plus the one requested last cycle.
    // A slot freed by this cycle's pop may be promised again.
    always_comb begin
        committed = {1'b0, fill} + EW'(req_q);
        capacity  = EW'(DEPTH) + EW'(pop);
        rd_en     = !rst && (committed < capacity);
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= rd_en;
    end

    // Data is new only when the enable of the previous cycle asked for it.
    assign push = req_q && in_val;

endmodule

// File: rtl/cwpa_skid.sv
module cwpa_skid #(
    parameter int W     = 11,
    parameter int DEPTH = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     wr_data,
    input  logic             ready,
    output logic             valid,
    output logic [W-1:0]     rd_data,
    output logic             pop,
    output logic [CNT_W-1:0] fill
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign valid   = (fill != '0);
    assign pop     = valid && ready;
    assign rd_data = slot[rd_ptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(i)) slot[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (fill < CNT_W'(DEPTH)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(rd_data)));

endmodule

// File: rtl/cwpa_frame_chk.sv
module cwpa_frame_chk
    import cwpa_pkg::*;
#(
    parameter int CW_LEN = 7,
    parameter int POS_W  = (CW_LEN > 1) ? $clog2(CW_LEN) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic sop,
    input  logic eop,
    output logic frame_err
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(CW_LEN - 1);

    logic [POS_W-1:0] pos;
    logic             at_start, at_last;
    frame_fault_e     fault;

    assign at_start = (pos == '0);
    assign at_last  = (pos == LAST_POS);

    always_comb begin
        fault = FE_NONE;
        if (push) fault = judge_symbol(sop, eop, at_start, at_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '0;
            frame_err <= 1'b0;
        end else if (push) begin
            if (fault != FE_NONE) frame_err <= 1'b1;
            if (sop)                  pos <= eop ? '0 : POS_W'(1);
            else if (at_start)        pos <= '0;
            else if (eop || at_last)  pos <= '0;
            else                      pos <= pos + 1'b1;
        end
    end

    // R9
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST_POS);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err);

endmodule

// File: rtl/cw_pull_adapter.sv
module cw_pull_adapter
    import cwpa_pkg::*;
#(
    parameter int SYM_W  = 8,
    parameter int CW_LEN = 7,
    parameter int DEPTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    output logic             rd_en,
    input  logic             in_val,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [SYM_W-1:0] in_sym,
    input  logic             in_erase,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_sop,
    output logic             out_eop,
    output logic [SYM_W-1:0] out_sym,
    output logic             out_erase
    ,
    output logic             frame_err
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ENT_W = SYM_W + TAG_W;

    typedef struct packed {
        logic [SYM_W-1:0] sym;
        sym_tag_t         tag;
    } entry_t;

    entry_t           in_ent, out_ent;
    logic             push, pop;
    logic [CNT_W-1:0] fill;

    assign in_ent.sym       = in_sym;
    assign in_ent.tag.sop   = in_sop;
    assign in_ent.tag.eop   = in_eop;
    assign in_ent.tag.erase = in_erase;

    cwpa_pull_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .fill   (fill),
        .pop    (pop),
        .in_val (in_val),
        .rd_en  (rd_en),
        .push   (push)
    );

    cwpa_skid #(.W(ENT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_skid (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .wr_data (in_ent),
        .ready   (out_ready),
        .valid   (out_valid),
        .rd_data (out_ent),
        .pop     (pop),
        .fill    (fill)
    );

    cwpa_frame_chk #(.CW_LEN(CW_LEN)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .sop       (in_sop),
        .eop       (in_eop),
        .frame_err (frame_err)
    );

    assign out_sym   = out_ent.sym;
    assign out_sop   = out_ent.tag.sop;
    assign out_eop   = out_ent.tag.eop;
    assign out_erase = out_ent.tag.erase;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !frame_err));

endmodule

// File: tb/cw_pull_adapter_test.sv
module cw_pull_adapter_test;
    localparam int SYM_W  = 8;
    localparam int CW_LEN = 7;
    localparam int DEPTH  = 2;
    localparam int QMAX   = 256;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rd_en;
    logic             in_val = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_erase = 1'b0;
    logic [SYM_W-1:0] in_sym = '0;
    logic             out_valid, out_ready = 1'b0;
    logic             out_sop, out_eop, out_erase, frame_err;
    logic [SYM_W-1:0] out_sym;

    cw_pull_adapter #(.SYM_W(SYM_W), .CW_LEN(CW_LEN), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en),
        .in_val(in_val), .in_sop(in_sop), .in_eop(in_eop),
        .in_sym(in_sym), .in_erase(in_erase),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sop(out_sop), .out_eop(out_eop), .out_sym(out_sym),
        .out_erase(out_erase), .frame_err(frame_err)
    );

    always #4 clk = ~clk;

    // Stimulus queue
    logic [SYM_W-1:0] q_sym [QMAX];
    logic             q_sop [QMAX];
    logic             q_eop [QMAX];
    logic             q_era [QMAX];
    int               q_len = 0;
    bit               gap_en = 1'b0;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int tx_ptr, rx_ptr, mism, hold_err, first_rx, last_rx, gap_ctr;
    logic en_seen = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Producer model: updates only on edges where the enable was high.
    always @(negedge clk) en_seen <= rd_en;

    always @(posedge clk) begin
        if (rst) begin
            in_val  <= 1'b0;
            tx_ptr  = 0;
            gap_ctr = 0;
        end else if (en_seen) begin
            gap_ctr = gap_ctr + 1;
            if (tx_ptr < q_len && !(gap_en && (gap_ctr % 3 == 1))) begin
                in_val   <= 1'b1;
                in_sym   <= q_sym[tx_ptr];
                in_sop   <= q_sop[tx_ptr];
                in_eop   <= q_eop[tx_ptr];
                in_erase <= q_era[tx_ptr];
                tx_ptr   = tx_ptr + 1;
            end else begin
                in_val <= 1'b0;
            end
        end
    end

    // Output monitor
    logic             p_stall;
    logic [SYM_W+2:0] p_word;
    always @(negedge clk) begin
        if (rst) begin
            rx_ptr = 0; mism = 0; hold_err = 0;
            first_rx = -1; last_rx = -1; p_stall = 1'b0; p_word = '0;
        end else begin
            if (p_stall && !(out_valid && {out_sym, out_sop, out_eop, out_erase} == p_word)) begin
                hold_err = hold_err + 1;
                $display("FAIL R4 held output changed: got %h exp %h", {out_sym, out_sop, out_eop, out_erase}, p_word);
            end
            if (out_valid && out_ready) begin
                if (rx_ptr >= q_len) begin
                    mism = mism + 1;
                    $display("FAIL R2 extra symbol %h: got index %0d exp below %0d", out_sym, rx_ptr, q_len);
                end else if ({out_sym, out_sop, out_eop, out_erase} !=
                             {q_sym[rx_ptr], q_sop[rx_ptr], q_eop[rx_ptr], q_era[rx_ptr]}) begin
                    mism = mism + 1;
                    $display("FAIL R3 symbol %0d: got %h exp %h", rx_ptr,
                             {out_sym, out_sop, out_eop, out_erase},
                             {q_sym[rx_ptr], q_sop[rx_ptr], q_eop[rx_ptr], q_era[rx_ptr]});
                end
                if (first_rx < 0) first_rx = cyc;
                last_rx = cyc;
                rx_ptr = rx_ptr + 1;
            end
            p_stall = out_valid && !out_ready;
            p_word  = {out_sym, out_sop, out_eop, out_erase};
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk = n_chk + 1; n_fail = n_fail + 1;
            $display("FAIL watchdog: got cycle %0d exp below 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic add_sym(input logic [SYM_W-1:0] s, input logic sp, input logic ep, input logic er);
        q_sym[q_len] = s; q_sop[q_len] = sp; q_eop[q_len] = ep; q_era[q_len] = er;
        q_len = q_len + 1;
    endtask

    task automatic add_good(input int ncw, input int seed);
        for (int c = 0; c < ncw; c++)
            for (int i = 0; i < CW_LEN; i++)
                add_sym(SYM_W'((seed + c * CW_LEN + i) * 37 + 5), i == 0, i == CW_LEN - 1, ((i + c) % 3) == 0);
    endtask

    task automatic hold_reset();
        rst = 1'b1; out_ready = 1'b0; gap_en = 1'b0; q_len = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic release_reset();
        @(posedge clk) #1 rst = 1'b0;
    endtask

    // mode 0: ready high; 1: alternating; 2: long stall; 3: pseudo-random
    task automatic run(input int mode, input bit gaps, input int max_cyc);
        logic [7:0] lf = 8'h5b;
        gap_en = gaps;
        for (int c = 0; c < max_cyc && rx_ptr < q_len; c++) begin
            @(posedge clk) #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = c[0];
                2: out_ready = !(c >= 5 && c < 30);
                default: out_ready = lf[0];
            endcase
            if (mode == 2 && c == 15) begin
                #1;
                // R5: enable withdrawn while the buffer is full and stalled
                check(rd_en == 1'b0 && out_valid, "R5 rd_en during stall", rd_en, 0);
            end
        end
        out_ready = 1'b1;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        hold_reset();
        @(negedge clk);
        check(rd_en == 1'b0, "R1 rd_en in reset", rd_en, 0);
        release_reset();
        @(negedge clk);
        check(!out_valid && !frame_err, "R1 outputs after reset", {out_valid, frame_err}, 0);
    endtask

    task automatic t_full_rate();
        hold_reset(); add_good(3, 1); release_reset();
        run(0, 1'b0, 300);
        check(rx_ptr == q_len, "R3 count full rate", rx_ptr, q_len);
        check(mism == 0, "R3 content full rate", mism, 0);
        check(last_rx - first_rx == q_len - 1, "R6 back-to-back span", last_rx - first_rx, q_len - 1);
        check(frame_err == 1'b0, "R10 no error on good stream", frame_err, 0);
    endtask

    task automatic t_alternate();
        hold_reset(); add_good(4, 20); release_reset();
        run(1, 1'b1, 600);
        check(rx_ptr == q_len && mism == 0, "R2 alternating ready with gaps", rx_ptr, q_len);
        check(hold_err == 0, "R4 hold under stall", hold_err, 0);
    endtask

    task automatic t_stall();
        hold_reset(); add_good(3, 50); release_reset();
        run(2, 1'b0, 600);
        check(rx_ptr == q_len && mism == 0, "R5 nothing lost across stall", rx_ptr, q_len);
        check(hold_err == 0, "R4 hold across long stall", hold_err, 0);
    endtask

    task automatic t_random();
        hold_reset(); add_good(5, 90); release_reset();
        run(3, 1'b1, 1500);
        check(rx_ptr == q_len && mism == 0, "R2 random ready with gaps", rx_ptr, q_len);
        check(frame_err == 1'b0, "R10 no error random", frame_err, 0);
    endtask

    task automatic t_no_sop();
        hold_reset();
        for (int i = 0; i < CW_LEN; i++) add_sym(SYM_W'(i + 3), 1'b0, i == CW_LEN - 1, 1'b0);
        release_reset();
        run(0, 1'b0, 200);
        check(frame_err == 1'b1, "R7 missing start marker", frame_err, 1);
        check(rx_ptr == q_len && mism == 0, "R3 data passes on error", rx_ptr, q_len);
    endtask

    task automatic t_mid_sop();
        hold_reset();
        for (int i = 0; i < CW_LEN; i++) add_sym(SYM_W'(i + 40), i == 0 || i == 3, i == CW_LEN - 1, 1'b1);
        release_reset();
        run(0, 1'b0, 200);
        check(frame_err == 1'b1, "R8 start marker mid codeword", frame_err, 1);
    endtask

    task automatic t_early_eop();
        hold_reset();
        for (int i = 0; i < 3; i++) add_sym(SYM_W'(i + 70), i == 0, i == 2, 1'b0);
        add_good(2, 7);
        release_reset();
        run(0, 1'b0, 300);
        check(frame_err == 1'b1, "R9 end marker too early, sticky over good codewords (R10)", frame_err, 1);
    endtask

    task automatic t_late_eop();
        hold_reset();
        for (int i = 0; i <= CW_LEN; i++) add_sym(SYM_W'(i + 90), i == 0, i == CW_LEN, 1'b0);
        release_reset();
        run(0, 1'b0, 200);
        check(frame_err == 1'b1, "R9 end marker missing at last position", frame_err, 1);
    endtask

    initial begin
        t_reset();
        t_full_rate();
        t_alternate();
        t_stall();
        t_random();
        t_no_sop();
        t_mid_sop();
        t_early_eop();
        t_late_eop();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule